// File: doc/BRIEF.md
# Electrically Erasable Word-Wide Memory Mode Decoder and Array Model

This block is a synthesizable, clock-driven model of a 16-bit-wide memory that is electrically erased and programmed. Every cycle it decodes one operating mode from six inputs: the active-low chip select, the active-low output gate, a 2-bit programming-supply level, a high-voltage flag on address bit 9, and address bit 0. Depending on that mode it returns a stored word, drives nothing, returns one of two fixed identifier words, or arms a word program or a whole-array erase.

A program or erase request is only armed while chip select is low. It is committed at the first clock edge that samples chip select high, and it is applied once. Programming can only clear bits. It ANDs the input word into the stored word. Only the whole-array erase sets bits back to one. The data bus is split into an input port and an output port, plus a drive flag that stands in for the tristate enable. Outputs are combinational from the inputs and the array.

Top module: `eprom_mode_model`

## Requirements
- R1: With supply level normal (2'b00, and the unused code 2'b11 behaves the same), chip select low, output gate low and the high-voltage flag clear, `rd_drive` is 1 and `rd_data` is the word at `addr`.
- R2: With normal supply and chip select high, `rd_drive` is 0 and `rd_data` is 0, whatever the output gate does.
- R3: With supply level program (2'b01), chip select low and output gate high, a program of `wr_data` at `addr` is armed. When it commits, the stored word becomes the old word AND `wr_data`, so no bit ever goes from 0 to 1.
- R4: With supply level erase (2'b10), the high-voltage flag set, chip select low, output gate high and `addr[0]` = 0, a chip erase is armed. When it commits, every word becomes 16'hFFFF. With `addr[0]` = 1 or the flag clear, nothing is armed and the outputs do not drive.
- R5: With supply program or erase, chip select high and output gate low, `rd_drive` is 1 and `rd_data` is the word at `addr`.
- R6: With supply program or erase and both chip select and output gate high, the outputs do not drive. Unless an armed operation is pending, the array does not change.
- R7: With the high-voltage flag set and both chip select and output gate low, at any supply level, `rd_drive` is 1. `rd_data` is 16'h00DA when `addr[0]` = 0 and 16'h000D when `addr[0]` = 1.
- R8: With normal supply, chip select low and output gate high, the outputs do not drive.
- R9: An armed operation commits at the first rising edge that samples chip select high, and only once. The array never changes at an edge that samples chip select low. An edge that samples chip select low in any mode other than program or erase cancels the armed operation.
- R10: A synchronous active-high reset sets every word to 16'hFFFF and cancels any armed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output gate, active low |
| supply_lvl | input | 2 | Programming supply: 00 normal, 01 program, 10 erase, 11 as normal |
| hv_line | input | 1 | High-voltage flag on address bit 9 |
| addr | input | AW | Word address; bit 0 also selects the identifier |
| wr_data | input | 16 | Word to program |
| rd_data | output | 16 | Output word, 0 when not driving |
| rd_drive | output | 1 | Output enable flag for the data bus |

## Verification
The hardest situations to reach are the edge where chip select rises while an operation is armed, and a program pulse that is cancelled before that edge. Both depend on the order of several cycles rather than on one input pattern. The stimulus holds a program pulse for several cycles and then raises chip select straight into verify or inhibit. It checks the old word in the cycle before the commit edge and the new word in the cycle after it. It also opens a pulse, drops the supply to normal while chip select is still low, and shows through verify that the word is untouched.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t ID_WORD_LO = 16'h00DA;
    localparam word_t ID_WORD_HI = 16'h000D;

    typedef enum logic [1:0] {
        SUP_NORMAL = 2'b00,
        SUP_PROG   = 2'b01,
        SUP_ERASE  = 2'b10,
        SUP_SPARE  = 2'b11
    } supply_e;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUT_OFF,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT,
        M_ERASE,
        M_IDENT
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10
    } op_e;

    function automatic word_t ident_word(input logic sel);
        return sel ? ID_WORD_HI : ID_WORD_LO;
    endfunction

    function automatic logic mode_drives(input mode_e m);
        return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
    endfunction

endpackage

// File: rtl/eprom_mode_decoder.sv
module eprom_mode_decoder
    import eprom_pkg::*;
(
    input  logic    chip_en_n,
    input  logic    out_en_n,
    input  supply_e sup,
    input  logic    hv_line,
    input  logic    addr_lsb,
    output mode_e   mode
);

    always_comb begin
        mode = M_STANDBY;
        if (!chip_en_n && !out_en_n && hv_line) begin
            mode = M_IDENT;
        end else begin
            case (sup)
                SUP_PROG, SUP_ERASE: begin
                    if (chip_en_n)
                        mode = out_en_n ? M_INHIBIT : M_VERIFY;
                    else if (!out_en_n)
                        mode = M_OUT_OFF;
                    else if (sup == SUP_PROG)
                        mode = M_PROGRAM;
                    else if (hv_line && !addr_lsb)
                        mode = M_ERASE;
                    else
                        mode = M_OUT_OFF;
                end
                default: begin
                    if (chip_en_n)
                        mode = M_STANDBY;
                    else
                        mode = out_en_n ? M_OUT_OFF : M_READ;
                end
            endcase
        end
    end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          chip_en_n,
    input  logic [AW-1:0] addr,
    input  word_t         wr_data,
    output word_t         stored
);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        word_t         data;
    } pend_t;

    logic [DEPTH-1:0][WORD_W-1:0] mem_q;
    pend_t pend_q;
    logic  prog_fire, erase_fire;

    assign prog_fire  = chip_en_n && (pend_q.op == OP_PROG);
    assign erase_fire = chip_en_n && (pend_q.op == OP_ERASE);
    assign stored     = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (chip_en_n) begin
            pend_q.op <= OP_NONE;
        end else begin
            case (mode)
                M_PROGRAM: pend_q <= '{op: OP_PROG, addr: addr, data: wr_data};
                M_ERASE:   pend_q.op <= OP_ERASE;
                default:   pend_q.op <= OP_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || erase_fire) begin
            mem_q <= '1;
        end else if (prog_fire) begin
            mem_q[pend_q.addr] <= mem_q[pend_q.addr] & pend_q.data;
        end
    end

    // R3
    prog_clears_only_chk: assert property (@(posedge clk) disable iff (rst)
        prog_fire |=> ((mem_q[$past(pend_q.addr)] & ~$past(mem_q[pend_q.addr])) == '0));

    // R4
    erase_fills_chk: assert property (@(posedge clk) disable iff (rst)
        erase_fire |=> (mem_q == '1));

    // R6
    inhibit_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_INHIBIT && pend_q.op == OP_NONE) |=> $stable(mem_q));

    // R9
    low_select_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !chip_en_n |=> $stable(mem_q));

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
    import eprom_pkg::*;
(
    input  mode_e mode,
    input  word_t stored,
    input  logic  addr_lsb,
    output word_t rd_data,
    output logic  rd_drive
);

    always_comb begin
        rd_drive = mode_drives(mode);
        if (mode == M_IDENT)
            rd_data = ident_word(addr_lsb);
        else if (rd_drive)
            rd_data = stored;
        else
            rd_data = '0;
    end

endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_en_n,
    input  logic          out_en_n,
    input  logic [1:0]    supply_lvl,
    input  logic          hv_line,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic          rd_drive
);

    supply_e sup;
    mode_e   mode;
    word_t   stored;
    logic    sup_raised;

    assign sup        = supply_e'(supply_lvl);
    assign sup_raised = (sup == SUP_PROG) || (sup == SUP_ERASE);

    eprom_mode_decoder u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .sup       (sup),
        .hv_line   (hv_line),
        .addr_lsb  (addr[0]),
        .mode      (mode)
    );

    eprom_cell_array #(.DEPTH(DEPTH)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .chip_en_n (chip_en_n),
        .addr      (addr),
        .wr_data   (wr_data),
        .stored    (stored)
    );

    eprom_out_stage u_out (
        .mode      (mode),
        .stored    (stored),
        .addr_lsb  (addr[0]),
        .rd_data   (rd_data),
        .rd_drive  (rd_drive)
    );

    // R1
    read_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (!sup_raised && !chip_en_n && !out_en_n && !hv_line) |-> rd_drive);

    // R2
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sup_raised && chip_en_n) |-> (!rd_drive && rd_data == '0));

    // R7
    ident_value_chk: assert property (@(posedge clk) disable iff (rst)
        (hv_line && !chip_en_n && !out_en_n) |->
            (rd_drive && (rd_data == (addr[0] ? 16'h000D : 16'h00DA))));

    // R8
    out_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sup_raised && !chip_en_n && out_en_n) |-> !rd_drive);

endmodule

// File: tb/sim_eprom_mode_model.sv
module sim_eprom_mode_model;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic [1:0]    supply_lvl = 2'b00;
    logic          hv_line = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;
    logic          rd_drive;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        drv;
        logic [15:0] dat;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    eprom_mode_model #(.DEPTH(DEPTH)) u0 (
        .clk        (clk),
        .rst        (rst),
        .chip_en_n  (chip_en_n),
        .out_en_n   (out_en_n),
        .supply_lvl (supply_lvl),
        .hv_line    (hv_line),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive)
    );

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic step(input logic cen, input logic oen, input logic [1:0] sup,
                        input logic hv, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic xdrv, input logic [15:0] xdat, input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        chip_en_n  = cen;
        out_en_n   = oen;
        supply_lvl = sup;
        hv_line    = hv;
        addr       = a;
        wr_data    = d;
        e.drv = xdrv;
        e.dat = xdat;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (rd_drive !== e.drv || rd_data !== e.dat) begin
                n_bad++;
                $display("FAIL %s: actual drive=%0b data=%h expected drive=%0b data=%h",
                         e.tag, rd_drive, rd_data, e.drv, e.dat);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R10 reset fills the array with ones
        step(0,0,2'b00,0,4'd0, 16'h0000, 1,16'hFFFF,"R10 word0");
        step(0,0,2'b00,0,4'd15,16'h0000, 1,16'hFFFF,"R10 word15");
        // R1 read via the spare supply code
        step(0,0,2'b11,0,4'd9, 16'h0000, 1,16'hFFFF,"R1 spare code");
        // R2 standby, both output gate levels
        step(1,0,2'b00,0,4'd3, 16'h0000, 0,16'h0000,"R2 gate low");
        step(1,1,2'b00,0,4'd3, 16'h0000, 0,16'h0000,"R2 gate high");
        // R8 output off
        step(0,1,2'b00,0,4'd3, 16'h0000, 0,16'h0000,"R8");
        // R3 program word 3, held two cycles
        step(0,1,2'b01,0,4'd3, 16'h1234, 0,16'h0000,"R3 pulse");
        step(0,1,2'b01,0,4'd3, 16'h1234, 0,16'h0000,"R3 pulse");
        step(1,0,2'b01,0,4'd3, 16'h0000, 1,16'hFFFF,"R9 before commit");
        step(1,0,2'b01,0,4'd3, 16'h0000, 1,16'h1234,"R5 verify");
        // R3 second program only clears bits
        step(0,1,2'b01,0,4'd3, 16'hFF0F, 0,16'h0000,"R3 pulse2");
        step(1,1,2'b01,0,4'd3, 16'h0000, 0,16'h0000,"R6 inhibit no drive");
        step(1,0,2'b01,0,4'd3, 16'h0000, 1,16'h1204,"R3 and result");
        // R6 inhibit without an armed operation
        step(1,1,2'b01,0,4'd5, 16'h0000, 0,16'h0000,"R6 inhibit");
        step(1,1,2'b10,1,4'd4, 16'h0000, 0,16'h0000,"R6 inhibit erase lvl");
        step(0,0,2'b00,0,4'd5, 16'h0000, 1,16'hFFFF,"R6 word5 kept");
        // R3 boundary address, commit into standby
        step(0,1,2'b01,0,4'd15,16'h00FF, 0,16'h0000,"R3 pulse top");
        step(1,0,2'b00,0,4'd15,16'h0000, 0,16'h0000,"R2 commit edge");
        step(0,0,2'b00,0,4'd15,16'h0000, 1,16'h00FF,"R1 top word");
        step(0,0,2'b00,0,4'd14,16'h0000, 1,16'hFFFF,"R3 neighbour");
        // R7 identifier words
        step(0,0,2'b00,1,4'd0, 16'h0000, 1,16'h00DA,"R7 lo");
        step(0,0,2'b00,1,4'd1, 16'h0000, 1,16'h000D,"R7 hi");
        step(0,0,2'b01,1,4'd2, 16'h0000, 1,16'h00DA,"R7 raised");
        // R4 erase refused with addr[0]=1
        step(0,1,2'b10,1,4'd1, 16'h0000, 0,16'h0000,"R4 refused");
        step(1,0,2'b10,0,4'd3, 16'h0000, 1,16'h1204,"R5 verify erase lvl");
        step(1,0,2'b10,0,4'd3, 16'h0000, 1,16'h1204,"R4 no erase");
        // R4 erase refused without the flag
        step(0,1,2'b10,0,4'd0, 16'h0000, 0,16'h0000,"R4 no flag");
        step(1,0,2'b10,0,4'd3, 16'h0000, 1,16'h1204,"R4 no flag kept");
        // R4 real erase
        step(0,1,2'b10,1,4'd0, 16'h0000, 0,16'h0000,"R4 pulse");
        step(1,0,2'b10,0,4'd3, 16'h0000, 1,16'h1204,"R9 erase pending");
        step(1,0,2'b10,0,4'd3, 16'h0000, 1,16'hFFFF,"R4 erased");
        step(0,0,2'b00,0,4'd15,16'h0000, 1,16'hFFFF,"R4 top erased");
        // R9 cancelled pulse
        step(0,1,2'b01,0,4'd7, 16'h0000, 0,16'h0000,"R9 pulse");
        step(0,1,2'b00,0,4'd7, 16'h0000, 0,16'h0000,"R9 cancel");
        step(1,0,2'b01,0,4'd7, 16'h0000, 1,16'hFFFF,"R9 rise");
        step(1,0,2'b01,0,4'd7, 16'h0000, 1,16'hFFFF,"R9 untouched");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule